// File: doc/BRIEF.md
# Dual-Mode Compare-Match PWM Timer

One timer channel. A 16-bit up-counter is compared against four compare registers, named A, B, C and D. The channel drives four waveform pins, one for each register. A compare match happens when the counter equals a register while counting is enabled. On a match, the register's 4-bit control field sets what the pin does: go low, go high, toggle, or hold. Any one of the four matches can be picked as the counter-clear source, so that register sets the period.

The channel is built around a three-state controller:

- **STOP** holds the counter and every pin at zero.
- **PAIR** uses two registers per pin. A and B steer pin 0, C and D steer pin 2, and pins 1 and 3 stay low.
- **CYC** uses the clear-source register as the period. Every other register sets the duty of its own pin. At each clear, those pins reload their initial level.

The mode input moves the controller. The named transitions are:

- Start-pair: STOP to PAIR.
- Start-cycle: STOP to CYC.
- Swap: PAIR to CYC, or CYC to PAIR.
- Halt: PAIR or CYC to STOP.

Every transition into an active state loads the initial levels.

Software writes the compare registers through a one-cycle write port. The control fields, the mode and the clear source are static inputs. They are expected to change only while the channel is in STOP.

Top module: `pwm_cm_timer`

## Requirements
- R1: While reset is asserted, `count` is 0 and every pin is 0. All four compare registers reset to all ones.
- R2: `mode_sel` set to 00 or 11 selects STOP. One clock later, `count` is 0 and all pins are 0, and they stay that way while STOP is held.
- R3: `mode_sel` 01 selects PAIR and 10 selects CYC. On the clock that enters a mode, `count` stays 0 and each pin used by that mode loads bit 3 of its control field. PAIR uses pins 0 and 2. CYC uses every pin except the clear-source pin.
- R4: In an active mode with `cnt_en` high, `count` rises by one per clock. With `cnt_en` low, no match is detected, and `count` and the pins hold.
- R5: With `clr_en` high, a match on the register picked by `clr_sel` (0=A, 1=B, 2=C, 3=D) makes `count` 0 on the next clock.
- R6: Control-field bits 1:0 select the action on a match: 00 no change, 01 low, 10 high, 11 toggle. Bit 2 is ignored. The pin updates on the clock after the match.
- R7: In PAIR, matches on A and B apply the A and B fields to pin 0, and matches on C and D apply the C and D fields to pin 2. Pins 1 and 3 stay 0.
- R8: In PAIR, if both registers of a pair hold the same value, that pair's pin does not change on their match.
- R9: In CYC, each non-period pin reloads its initial level (bit 3) on every clear. The reload takes priority over that pin's own action in the same cycle.
- R10: In CYC, the pin of the clear-source register stays 0.
- R11: In CYC, a duty register equal to the period register causes no action on its pin.
- R12: In CYC, a duty value at or above the period gives a constant pin level. This yields 0% duty (initial low, action high) and 100% duty (initial high, action low).
- R13: A write with `wr_en` high loads `wr_data` into the register picked by `wr_sel` (0=A, 1=B, 2=C, 3=D) at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Compare register write strobe |
| wr_sel | input | 2 | Register picked for the write |
| wr_data | input | 16 | Write data |
| mode_sel | input | 2 | 01 paired, 10 cycle/duty, other stop |
| cnt_en | input | 1 | Count enable |
| clr_en | input | 1 | Enables counter clear on the chosen match |
| clr_sel | input | 2 | Clear-source register (period register in CYC) |
| ctl_fld | input | 16 | Control field of register i in bits 4i+3:4i |
| count | output | 16 | Counter value |
| pin_o | output | 4 | Waveform pins, bit i for register i |

## Verification
The hardest situations to reach are the coincidences: a duty or partner value equal to the period, and a duty value beyond the period. In these, the equality suppression and the clear reload decide the level with no visible edge.

The stimulus sweeps one duty value across every position from 0 up to one past the period. Each configuration runs for several periods. Expected levels are computed per count by walking back through the matches of the previous period. A rotated offset puts the other registers through the same coincidences at the same time.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    localparam int NUM_CMP  = 4;
    localparam int CTL_W    = 4;
    localparam int INIT_BIT = 3;

    localparam logic [1:0] ACT_NONE = 2'b00;
    localparam logic [1:0] ACT_LO   = 2'b01;
    localparam logic [1:0] ACT_HI   = 2'b10;
    localparam logic [1:0] ACT_TGL  = 2'b11;

    localparam logic [1:0] MODE_PAIR = 2'b01;
    localparam logic [1:0] MODE_CYC  = 2'b10;

    typedef enum logic [1:0] {
        S_STOP = 2'd0,
        S_PAIR = 2'd1,
        S_CYC  = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank #(
    parameter int CNT_W = 16,
    parameter int NCMP  = 4,
    localparam int SEL_W = $clog2(NCMP)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [CNT_W-1:0]           wr_data,
    input  logic [CNT_W-1:0]           count,
    input  logic                       arm,
    output logic [NCMP-1:0][CNT_W-1:0] cmp_q,
    output logic [NCMP-1:0]            hit
);

    for (genvar i = 0; i < NCMP; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_q[i] <= '1;
            end else if (wr_en && (wr_sel == SEL_W'(i))) begin
                cmp_q[i] <= wr_data;
            end
        end

        // a match only counts while the counter is armed
        assign hit[i] = arm && (count == cmp_q[i]);
    end

endmodule

// File: rtl/pwm_up_counter.sv
module pwm_up_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_zero,
    input  logic             run,
    input  logic             cnt_en,
    input  logic             clr_hit,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (hold_zero) begin
            count <= '0;
        end else if (run && cnt_en) begin
            if (clr_hit) begin
                count <= '0;
            end else begin
                count <= count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/pwm_pin_ctl.sv
module pwm_pin_ctl
    import pwm_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       force_lo,
    input  logic       load,
    input  logic       load_lvl,
    input  logic       apply,
    input  logic [1:0] act,
    output logic       pin
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else if (force_lo) begin
            pin <= 1'b0;
        end else if (load) begin
            pin <= load_lvl;
        end else if (apply) begin
            unique case (act)
                ACT_LO:   pin <= 1'b0;
                ACT_HI:   pin <= 1'b1;
                ACT_TGL:  pin <= ~pin;
                default:  pin <= pin;
            endcase
        end
    end

endmodule

// File: rtl/pwm_cm_timer.sv
module pwm_cm_timer
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int SEL_W = $clog2(NUM_CMP),
    localparam int FLD_W = NUM_CMP * CTL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       mode_sel,
    input  logic             cnt_en,
    input  logic             clr_en,
    input  logic [SEL_W-1:0] clr_sel,
    input  logic [FLD_W-1:0] ctl_fld,
    output logic [CNT_W-1:0] count,
    output logic [NUM_CMP-1:0] pin_o
);

    tmr_state_e st_q;
    tmr_state_e st_nxt;

    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
    logic [NUM_CMP-1:0]            hit;
    logic                          run;
    logic                          entry;
    logic                          clr_hit;

    logic [NUM_CMP-1:0]       frc_lo;
    logic [NUM_CMP-1:0]       ld;
    logic [NUM_CMP-1:0]       ld_lvl;
    logic [NUM_CMP-1:0]       app;
    logic [NUM_CMP-1:0][1:0]  act;

    logic unused_rsv;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_STOP;
        end else begin
            st_q <= st_nxt;
        end
    end

    // ---------------- transitions ----------------
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            S_STOP: begin
                if (mode_sel == MODE_PAIR) begin
                    st_nxt = S_PAIR;            // start-pair
                end else if (mode_sel == MODE_CYC) begin
                    st_nxt = S_CYC;             // start-cycle
                end
            end
            S_PAIR: begin
                if (mode_sel == MODE_CYC) begin
                    st_nxt = S_CYC;             // swap
                end else if (mode_sel != MODE_PAIR) begin
                    st_nxt = S_STOP;            // halt
                end
            end
            S_CYC: begin
                if (mode_sel == MODE_PAIR) begin
                    st_nxt = S_PAIR;            // swap
                end else if (mode_sel != MODE_CYC) begin
                    st_nxt = S_STOP;            // halt
                end
            end
            default: st_nxt = S_STOP;
        endcase
    end

    assign run     = (st_q != S_STOP);
    assign entry   = (st_nxt != st_q);
    assign clr_hit = clr_en && hit[clr_sel];

    // ---------------- datapath blocks ----------------
    pwm_cmp_bank #(
        .CNT_W (CNT_W),
        .NCMP  (NUM_CMP)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .count   (count),
        .arm     (run && cnt_en),
        .cmp_q   (cmp_q),
        .hit     (hit)
    );

    pwm_up_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_zero (st_nxt == S_STOP),
        .run       (run),
        .cnt_en    (cnt_en),
        .clr_hit   (clr_hit),
        .count     (count)
    );

    // ---------------- output process, one slice per pin ----------------
    for (genvar p = 0; p < NUM_CMP; p++) begin : g_pin
        logic [CTL_W-1:0] own_fld;
        logic             pair_slot;
        logic             prt_hit;
        logic [1:0]       prt_act;
        logic             prt_eq;

        assign own_fld   = ctl_fld[p*CTL_W +: CTL_W];
        assign pair_slot = ((p % 2) == 0);

        if ((p % 2) == 0) begin : g_even
            assign prt_hit = hit[p+1];
            assign prt_act = ctl_fld[(p+1)*CTL_W +: 2];
            assign prt_eq  = (cmp_q[p] == cmp_q[p+1]);
        end else begin : g_odd
            assign prt_hit = 1'b0;
            assign prt_act = ACT_NONE;
            assign prt_eq  = 1'b0;
        end

        always_comb begin
            frc_lo[p] = 1'b0;
            ld[p]     = 1'b0;
            ld_lvl[p] = own_fld[INIT_BIT];
            app[p]    = 1'b0;
            act[p]    = ACT_NONE;
            if (st_nxt == S_STOP) begin
                frc_lo[p] = 1'b1;
            end else if (entry) begin
                if (st_nxt == S_PAIR) begin
                    if (pair_slot) ld[p] = 1'b1;
                    else           frc_lo[p] = 1'b1;
                end else begin
                    if (clr_sel == SEL_W'(p)) frc_lo[p] = 1'b1;
                    else                      ld[p] = 1'b1;
                end
            end else begin
                unique case (st_q)
                    S_PAIR: begin
                        if (!pair_slot) begin
                            frc_lo[p] = 1'b1;
                        end else if (!prt_eq) begin
                            if (hit[p]) begin
                                app[p] = 1'b1;
                                act[p] = own_fld[1:0];
                            end else if (prt_hit) begin
                                app[p] = 1'b1;
                                act[p] = prt_act;
                            end
                        end
                    end
                    S_CYC: begin
                        if (clr_sel == SEL_W'(p)) begin
                            frc_lo[p] = 1'b1;
                        end else if (clr_hit) begin
                            ld[p] = 1'b1;           // reload wins
                        end else if (hit[p] && (cmp_q[p] != cmp_q[clr_sel])) begin
                            app[p] = 1'b1;
                            act[p] = own_fld[1:0];
                        end
                    end
                    default: frc_lo[p] = 1'b1;
                endcase
            end
        end

        pwm_pin_ctl u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .force_lo (frc_lo[p]),
            .load     (ld[p]),
            .load_lvl (ld_lvl[p]),
            .apply    (app[p]),
            .act      (act[p]),
            .pin      (pin_o[p])
        );
    end

    // reserved bit 2 of every field carries no function
    assign unused_rsv = ^{ctl_fld[2], ctl_fld[6], ctl_fld[10], ctl_fld[14]};

endmodule

// File: rtl/pwm_cm_timer_chk.sv
module pwm_cm_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           mode_sel,
    input logic                 cnt_en,
    input logic                 clr_en,
    input logic [1:0]           clr_sel,
    input logic [CNT_W-1:0]     count,
    input logic [3:0]           pin_o,
    input logic [1:0]           st_cur,
    input logic [1:0]           st_nx,
    input logic [3:0][CNT_W-1:0] cmp_q
);

    logic       seen;
    logic [1:0] sel_d;
    logic       clr_now;
    logic       stop_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen  <= 1'b0;
            sel_d <= 2'd0;
        end else begin
            seen  <= 1'b1;
            sel_d <= clr_sel;
        end
    end

    assign clr_now  = cnt_en && clr_en && (st_cur != 2'd0) && (st_nx != 2'd0)
                      && (count == cmp_q[clr_sel]);
    assign stop_req = (mode_sel == 2'b00) || (mode_sel == 2'b11);

    // R2
    a_r2_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(stop_req)) |-> (count == '0 && pin_o == 4'b0));

    // R4
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(!cnt_en && st_cur != 2'd0 && st_nx == st_cur))
        |-> ($stable(count) && $stable(pin_o)));

    // R5
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(clr_now)) |-> (count == '0));

    // R7
    a_r7_pair_spare_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_cur == 2'd1) |-> (pin_o[1] == 1'b0 && pin_o[3] == 1'b0));

    // R8
    a_r8_pair_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(st_cur == 2'd1 && st_nx == 2'd1 && cmp_q[0] == cmp_q[1]))
        |-> $stable(pin_o[0]));

    // R10
    a_r10_cycle_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && st_cur == 2'd2) |-> (pin_o[sel_d] == 1'b0));

endmodule

bind pwm_cm_timer pwm_cm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .cnt_en   (cnt_en),
    .clr_en   (clr_en),
    .clr_sel  (clr_sel),
    .count    (count),
    .pin_o    (pin_o),
    .st_cur   (st_q),
    .st_nx    (st_nxt),
    .cmp_q    (cmp_q)
);

// File: tb/tb_pwm_cm_timer.sv
module tb_pwm_cm_timer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic [1:0]  mode_sel;
    logic        cnt_en;
    logic        clr_en;
    logic [1:0]  clr_sel;
    logic [15:0] ctl_fld;
    logic [15:0] count;
    logic [3:0]  pin_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    int         cfg_cmp [4];
    logic [3:0] cfg_ctl [4];
    logic [1:0] cfg_mode;
    int         cfg_clr;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_cm_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .mode_sel(mode_sel), .cnt_en(cnt_en), .clr_en(clr_en), .clr_sel(clr_sel),
        .ctl_fld(ctl_fld), .count(count), .pin_o(pin_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pair_lvl(int k, int per, int o, int q);
        logic [1:0] ao   = cfg_ctl[o][1:0];
        logic [1:0] aq   = cfg_ctl[q][1:0];
        int         x    = cfg_cmp[o];
        int         y    = cfg_cmp[q];
        logic       init = cfg_ctl[o][3];
        if (x == y) return init;
        if (ao == 2'b11 && aq == 2'b11) return init ^ ((k > x) && (k <= y));
        for (int j = 1; j <= per + 1; j++) begin
            int c = (k - j + per + 1) % (per + 1);
            if (c == x && ao != 2'b00) return (ao == 2'b10);
            if (c == y && aq != 2'b00) return (aq == 2'b10);
        end
        return init;
    endfunction

    function automatic logic cyc_lvl(int k, int per, int p);
        int         d    = cfg_cmp[p];
        logic       init = cfg_ctl[p][3];
        logic [1:0] a    = cfg_ctl[p][1:0];
        if (d < per && k > d) begin
            case (a)
                2'b01:   return 1'b0;
                2'b10:   return 1'b1;
                2'b11:   return ~init;
                default: return init;
            endcase
        end
        return init;
    endfunction

    function automatic logic [3:0] exp_pins(int k);
        logic [3:0] e = 4'b0;
        int per = cfg_cmp[cfg_clr];
        if (cfg_mode == 2'b01) begin
            e[0] = pair_lvl(k, per, 0, 1);
            e[2] = pair_lvl(k, per, 2, 3);
        end else begin
            for (int p = 0; p < 4; p++)
                e[p] = (p == cfg_clr) ? 1'b0 : cyc_lvl(k, per, p);
        end
        return e;
    endfunction

    function automatic logic [3:0] entry_pins();
        logic [3:0] e = 4'b0;
        for (int p = 0; p < 4; p++) begin
            if (cfg_mode == 2'b01) e[p] = ((p % 2) == 0) ? cfg_ctl[p][3] : 1'b0;
            else                   e[p] = (p == cfg_clr) ? 1'b0 : cfg_ctl[p][3];
        end
        return e;
    endfunction

    // stop, program, start, then check several periods
    task automatic run_cfg(input string tag);
        int per = cfg_cmp[cfg_clr];
        bit steady = 0;
        int prev;
        mode_sel = 2'b00;
        cnt_en   = 1'b1;
        @(negedge clk);
        chk(count == 16'd0 && pin_o == 4'b0, "R2 stop idle", int'(pin_o), 0);
        for (int i = 0; i < 4; i++) begin
            wr_en   = 1'b1;
            wr_sel  = 2'(i);
            wr_data = 16'(cfg_cmp[i]);
            @(negedge clk);
        end
        wr_en   = 1'b0;
        ctl_fld = {cfg_ctl[3], cfg_ctl[2], cfg_ctl[1], cfg_ctl[0]};
        clr_en  = 1'b1;
        clr_sel = 2'(cfg_clr);
        @(negedge clk);
        chk(count == 16'd0, "R2 stop holds count", int'(count), 0);
        mode_sel = cfg_mode;
        @(negedge clk);
        chk(count == 16'd0 && pin_o == entry_pins(), {"R3 entry ", tag},
            int'(pin_o), int'(entry_pins()));
        prev = 0;
        for (int n = 1; n <= 3 * (per + 1); n++) begin
            int k;
            @(negedge clk);
            k = int'(count);
            chk(k == ((prev == per) ? 0 : prev + 1), "R4 R5 count sequence",
                k, (prev == per) ? 0 : prev + 1);
            if (k == 0) steady = 1;
            if (steady)
                chk(pin_o == exp_pins(k), tag, int'(pin_o), int'(exp_pins(k)));
            prev = k;
        end
    endtask

    initial begin
        rst_n    = 1'b0;
        wr_en    = 1'b0;
        wr_sel   = 2'd0;
        wr_data  = 16'd0;
        mode_sel = 2'b00;
        cnt_en   = 1'b0;
        clr_en   = 1'b0;
        clr_sel  = 2'd0;
        ctl_fld  = 16'd0;
        repeat (3) @(negedge clk);
        chk(count == 16'd0 && pin_o == 4'b0, "R1 reset state", int'(pin_o), 0);
        rst_n = 1'b1;
        mode_sel = 2'b11;
        cnt_en   = 1'b1;
        repeat (4) @(negedge clk);
        chk(count == 16'd0 && pin_o == 4'b0, "R2 mode 11 stop", int'(count), 0);

        // paired sweep, clear on B (period 5)
        cfg_mode = 2'b01;
        cfg_clr  = 1;
        cfg_ctl[0] = 4'b0010; cfg_ctl[1] = 4'b0001;
        cfg_ctl[2] = 4'b1101; cfg_ctl[3] = 4'b0110;   // bit 2 set: ignored (R6)
        for (int a = 0; a <= 6; a++) begin
            cfg_cmp[0] = a;
            cfg_cmp[1] = 5;
            cfg_cmp[2] = (a + 3) % 7;
            cfg_cmp[3] = (2 * a) % 7;
            run_cfg("R6 R7 R8 R13 paired");
        end

        // paired toggle, clear on D (period 5), C/D take no action
        cfg_clr = 3;
        cfg_ctl[0] = 4'b1011; cfg_ctl[1] = 4'b0011;
        cfg_ctl[2] = 4'b1000; cfg_ctl[3] = 4'b0000;
        cfg_cmp[0] = 1; cfg_cmp[1] = 4; cfg_cmp[2] = 2; cfg_cmp[3] = 5;
        run_cfg("R6 toggle paired");

        // cycle/duty sweep, period on D = 6
        cfg_mode = 2'b10;
        cfg_clr  = 3;
        cfg_ctl[0] = 4'b0010; cfg_ctl[1] = 4'b1001;
        cfg_ctl[2] = 4'b0011; cfg_ctl[3] = 4'b1010;
        for (int d = 0; d <= 7; d++) begin
            cfg_cmp[0] = d;
            cfg_cmp[1] = (d + 3) % 8;
            cfg_cmp[2] = (d + 5) % 8;
            cfg_cmp[3] = 6;
            run_cfg("R9 R10 R11 R12 cycle");
        end

        // cycle/duty with period on A = 4
        cfg_clr = 0;
        cfg_ctl[0] = 4'b1010; cfg_ctl[1] = 4'b0010;
        cfg_ctl[2] = 4'b1001; cfg_ctl[3] = 4'b0010;
        cfg_cmp[0] = 4; cfg_cmp[1] = 2; cfg_cmp[2] = 0; cfg_cmp[3] = 4;
        run_cfg("R10 R11 cycle on A");

        // count enable low: everything freezes
        begin
            logic [15:0] c0;
            logic [3:0]  p0;
            @(negedge clk);
            cnt_en = 1'b0;
            @(negedge clk);
            c0 = count;
            p0 = pin_o;
            for (int n = 0; n < 6; n++) begin
                @(negedge clk);
                chk(count == c0 && pin_o == p0, "R4 hold when disabled",
                    int'(count), int'(c0));
            end
            cnt_en = 1'b1;
            @(negedge clk);
            chk(int'(count) == ((int'(c0) == 4) ? 0 : int'(c0) + 1), "R4 resume",
                int'(count), (int'(c0) == 4) ? 0 : int'(c0) + 1);
        end

        // halt from an active mode
        mode_sel = 2'b00;
        @(negedge clk);
        chk(count == 16'd0 && pin_o == 4'b0, "R2 halt", int'(pin_o), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule